// File: doc/BRIEF.md
# UART Channel Register Set

This block is the software-visible register file of one UART channel. A byte-wide register bus with a 6-bit address and separate read and write strobes reaches two mode registers, a status byte, a command port, a transmit holding register, an interrupt status and mask pair, and two read-only bytes that show the baud divisor. The serial shifter, the baud generator and the receive FIFO are outside the block. The block talks to them over small side interfaces:

- It hands each transmit byte to the shifter as a single-cycle valid pulse.
- It pops the receive FIFO when software reads the data port.
- It flushes that FIFO on a receiver reset.
- It takes the FIFO's ready, full and error flags, together with a break-change event, as inputs.

A command write carries three independent fields in one byte: a receiver control, a transmitter control and a miscellaneous action. The miscellaneous action is applied first, so an enable in the same byte takes effect after a reset. One level interrupt output is the OR of the interrupt status bits that the mask allows. The receive interrupt source is chosen by a bit of the first mode register.

Top module: `uart_regs`

## Requirements
- R1: After reset both mode registers, the mode pointer, the mask, the break flag and both enables are zero, and the status byte reads 0x08 (transmitter empty only) when the FIFO flags are low.
- R2: A write to offset 0x00 stores into the mode register the pointer selects and then sets the pointer to 1. A read of 0x00 returns the selected register. Miscellaneous code 1 returns the pointer to 0.
- R3: A read of offset 0x04 returns the status byte: bit0 FIFO ready, bit1 FIFO full, bit2 transmitter enabled, bit3 transmitter empty, bits 7:4 the four receive error flags (overrun, parity, framing, break in that order).
- R4: Command bits [1:0] control the receiver: 1 enables it, 2 disables it, 0 and 3 change nothing. `rx_en_o` shows the receiver enable.
- R5: Command bits [3:2] control the transmitter with the same encoding. Transmitter ready (status bit2) equals the transmitter enable.
- R6: Miscellaneous code 2 (command bits [6:4]) disables the receiver and raises `rx_flush_o` during the command write. A receiver enable in the same byte leaves the receiver enabled.
- R7: Miscellaneous code 3 disables the transmitter, sets the empty flag and drops any pending byte. A transmitter enable in the same byte leaves the transmitter enabled.
- R8: A write to offset 0x0C latches the byte and clears the empty flag. While the transmitter is enabled and a byte is pending, `tx_valid_o` is high for one cycle with the byte on `tx_data_o`, and the empty flag is set at the end of that cycle. A transmit write in the hand-off cycle wins over the set.
- R9: The interrupt status read at 0x14 has bit0 equal to transmitter ready. Bit1 equals FIFO full when mode register 0 bit6 is 1, and FIFO ready otherwise. Bit2 is the break flag. Bits 7:3 are zero.
- R10: `brk_evt_i` sets the break flag on the next edge. Miscellaneous code 5 clears it. A set in the same cycle as a clear wins.
- R11: A write to 0x14 loads the mask. `irq_o` is high exactly when the interrupt status AND the mask is nonzero.
- R12: A read of 0x0C returns `rx_data_i` and raises `rx_pop_o` in that cycle. Offsets 0x18 and 0x1C return the high and low divisor bytes. Every other offset, and any cycle without a read strobe, returns 0.
- R13: Writes to offsets other than 0x00, 0x08, 0x0C and 0x14 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Register byte address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid while rd_i is high |
| irq_o | output | 1 | Level interrupt |
| tx_valid_o | output | 1 | Transmit byte hand-off pulse |
| tx_data_o | output | 8 | Transmit byte |
| rx_data_i | input | 8 | Receive FIFO head byte |
| rx_ready_i | input | 1 | Receive FIFO not empty |
| rx_full_i | input | 1 | Receive FIFO full |
| rx_err_i | input | 4 | Overrun, parity, framing, break flags |
| rx_pop_o | output | 1 | Pop the receive FIFO |
| rx_flush_o | output | 1 | Empty the receive FIFO |
| rx_en_o | output | 1 | Receiver enable |
| brk_evt_i | input | 1 | Break-change event |
| baud_div_i | input | 16 | Baud divisor for readback |

## Verification
Two cases are hard to reach from the ports: a command byte whose miscellaneous reset and whose enable field act on the same channel, and a transmit write that lands in the very cycle a previous byte is being handed off. Directed sequences build both. The first uses combined command bytes. The second enables the transmitter and then writes back-to-back into the holding register. A long random run of mixed reads, writes of arbitrary command bytes, stray-address writes and break events is then compared against a cycle-level model in the bench. That run also reaches mask and pointer combinations that the directed part does not list.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] OFF_MODE   = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_CMD    = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_DATA   = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_IRQ    = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_DIV_HI = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_DIV_LO = 6'h1C;

  typedef enum logic [2:0] {
    MISC_NOP     = 3'd0,
    MISC_PTR_RST = 3'd1,
    MISC_RX_RST  = 3'd2,
    MISC_TX_RST  = 3'd3,
    MISC_ERR_RST = 3'd4,
    MISC_BRK_CLR = 3'd5,
    MISC_BRK_ON  = 3'd6,
    MISC_BRK_OFF = 3'd7
  } misc_e;

  typedef enum logic [1:0] {
    CH_NOP  = 2'd0,
    CH_ON   = 2'd1,
    CH_OFF  = 2'd2,
    CH_RSVD = 2'd3
  } chan_e;

  typedef struct packed {
    logic  spare;
    misc_e misc;
    chan_e tx;
    chan_e rx;
  } cmd_t;
endpackage

// File: rtl/uart_cmd_dec.sv
module uart_cmd_dec
  import uart_regs_pkg::*;
(
  input  logic              cmd_wr_i,
  input  logic [DATA_W-1:0] cmd_i,
  output logic              ptr_rst_o,
  output logic              rx_rst_o,
  output logic              tx_rst_o,
  output logic              brk_clr_o,
  output logic              rx_on_o,
  output logic              rx_off_o,
  output logic              tx_on_o,
  output logic              tx_off_o
);
  cmd_t cmd;
  assign cmd = cmd_t'(cmd_i);

  always_comb begin
    ptr_rst_o = 1'b0;
    rx_rst_o  = 1'b0;
    tx_rst_o  = 1'b0;
    brk_clr_o = 1'b0;
    if (cmd_wr_i) begin
      case (cmd.misc)
        MISC_PTR_RST: ptr_rst_o = 1'b1;
        MISC_RX_RST:  rx_rst_o  = 1'b1;
        MISC_TX_RST:  tx_rst_o  = 1'b1;
        MISC_BRK_CLR: brk_clr_o = 1'b1;
        default: ;
      endcase
    end
  end

  assign rx_on_o  = cmd_wr_i && (cmd.rx == CH_ON);
  assign rx_off_o = cmd_wr_i && (cmd.rx == CH_OFF);
  assign tx_on_o  = cmd_wr_i && (cmd.tx == CH_ON);
  assign tx_off_o = cmd_wr_i && (cmd.tx == CH_OFF);
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
  import uart_regs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tb_wr_i,
  input  logic [DATA_W-1:0] tb_data_i,
  input  logic              tx_rst_i,
  input  logic              tx_on_i,
  input  logic              tx_off_i,
  output logic              tx_en_o,
  output logic              tx_empty_o,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o
);
  logic              en_q, empty_q;
  logic [DATA_W-1:0] tb_q;

  assign tx_valid_o = en_q && !empty_q;
  assign tx_data_o  = tb_q;
  assign tx_en_o    = en_q;
  assign tx_empty_o = empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      empty_q <= 1'b1;
      tb_q    <= '0;
    end else begin
      // reset first, field enable overrides
      if (tx_rst_i) en_q <= 1'b0;
      if (tx_on_i) en_q <= 1'b1;
      else if (tx_off_i) en_q <= 1'b0;
      if (tx_valid_o || tx_rst_i) empty_q <= 1'b1;
      if (tb_wr_i) begin
        empty_q <= 1'b0;
        tb_q    <= tb_data_i;
      end
    end
  end

  // R8
  handoff_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tb_wr_i |=> !tx_valid_o);
  // R5
  tx_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_off_i |=> !tx_en_o);
  // R7
  tx_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_rst_i && !tx_on_i |=> tx_empty_o && !tx_en_o);
endmodule

// File: rtl/uart_irq_ctl.sv
module uart_irq_ctl
  import uart_regs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              brk_evt_i,
  input  logic              brk_clr_i,
  input  logic              tx_rdy_i,
  input  logic              rx_rdy_i,
  input  logic              rx_full_i,
  input  logic              rx_sel_full_i,
  input  logic [DATA_W-1:0] imr_i,
  output logic [DATA_W-1:0] isr_o,
  output logic              irq_o
);
  logic brk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        brk_q <= 1'b0;
    else if (brk_evt_i) brk_q <= 1'b1;
    else if (brk_clr_i) brk_q <= 1'b0;
  end

  always_comb begin
    isr_o    = '0;
    isr_o[0] = tx_rdy_i;
    isr_o[1] = rx_sel_full_i ? rx_full_i : rx_rdy_i;
    isr_o[2] = brk_q;
  end

  assign irq_o = |(isr_o & imr_i);

  // R10
  brk_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_evt_i |=> isr_o[2]);
  // R10
  brk_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_clr_i && !brk_evt_i |=> !isr_o[2]);
  // R11
  irq_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imr_i == '0 |-> !irq_o);
endmodule

// File: rtl/uart_regs.sv
module uart_regs
  import uart_regs_pkg::*;
#(
  parameter int NUM_MODE = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                irq_o,
  output logic                tx_valid_o,
  output logic [DATA_W-1:0]   tx_data_o,
  input  logic [DATA_W-1:0]   rx_data_i,
  input  logic                rx_ready_i,
  input  logic                rx_full_i,
  input  logic [3:0]          rx_err_i,
  output logic                rx_pop_o,
  output logic                rx_flush_o,
  output logic                rx_en_o,
  input  logic                brk_evt_i,
  input  logic [2*DATA_W-1:0] baud_div_i
);
  localparam int PTR_W = (NUM_MODE > 1) ? $clog2(NUM_MODE) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NUM_MODE - 1);

  logic wr_mode, wr_cmd, wr_data, wr_imr;
  logic ptr_rst, rx_rst, tx_rst, brk_clr, rx_on, rx_off, tx_on, tx_off;
  logic tx_en, tx_empty;
  logic [PTR_W-1:0]  ptr_q;
  logic [DATA_W-1:0] mr_q [NUM_MODE];
  logic [DATA_W-1:0] imr_q, sr, isr;
  logic              rx_en_q;

  assign wr_mode = wr_i && (addr_i == OFF_MODE);
  assign wr_cmd  = wr_i && (addr_i == OFF_CMD);
  assign wr_data = wr_i && (addr_i == OFF_DATA);
  assign wr_imr  = wr_i && (addr_i == OFF_IRQ);

  uart_cmd_dec i_cmd_dec (
    .cmd_wr_i (wr_cmd),
    .cmd_i    (wdata_i),
    .ptr_rst_o(ptr_rst),
    .rx_rst_o (rx_rst),
    .tx_rst_o (tx_rst),
    .brk_clr_o(brk_clr),
    .rx_on_o  (rx_on),
    .rx_off_o (rx_off),
    .tx_on_o  (tx_on),
    .tx_off_o (tx_off)
  );

  for (genvar g = 0; g < NUM_MODE; g++) begin : g_mode
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mr_q[g] <= '0;
      else if (wr_mode && ptr_q == PTR_W'(g)) mr_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      imr_q   <= '0;
      rx_en_q <= 1'b0;
    end else begin
      if (wr_mode) ptr_q <= PTR_LAST;
      else if (ptr_rst) ptr_q <= '0;
      if (wr_imr) imr_q <= wdata_i;
      if (rx_rst) rx_en_q <= 1'b0;
      if (rx_on) rx_en_q <= 1'b1;
      else if (rx_off) rx_en_q <= 1'b0;
    end
  end

  uart_tx_hold i_tx_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tb_wr_i   (wr_data),
    .tb_data_i (wdata_i),
    .tx_rst_i  (tx_rst),
    .tx_on_i   (tx_on),
    .tx_off_i  (tx_off),
    .tx_en_o   (tx_en),
    .tx_empty_o(tx_empty),
    .tx_valid_o(tx_valid_o),
    .tx_data_o (tx_data_o)
  );

  assign sr = {rx_err_i, tx_empty, tx_en, rx_full_i, rx_ready_i};

  uart_irq_ctl i_irq_ctl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .brk_evt_i    (brk_evt_i),
    .brk_clr_i    (brk_clr),
    .tx_rdy_i     (tx_en),
    .rx_rdy_i     (rx_ready_i),
    .rx_full_i    (rx_full_i),
    .rx_sel_full_i(mr_q[0][6]),
    .imr_i        (imr_q),
    .isr_o        (isr),
    .irq_o        (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (addr_i)
        OFF_MODE:   rdata_o = mr_q[ptr_q];
        OFF_STAT:   rdata_o = sr;
        OFF_DATA:   rdata_o = rx_data_i;
        OFF_IRQ:    rdata_o = isr;
        OFF_DIV_HI: rdata_o = baud_div_i[2*DATA_W-1:DATA_W];
        OFF_DIV_LO: rdata_o = baud_div_i[DATA_W-1:0];
        default:    rdata_o = '0;
      endcase
    end
  end

  assign rx_pop_o   = rd_i && (addr_i == OFF_DATA);
  assign rx_flush_o = rx_rst;
  assign rx_en_o    = rx_en_q;

  // R2
  ptr_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mode |=> ptr_q == PTR_LAST);
  // R4
  rx_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_off |=> !rx_en_o);
  // R6
  rx_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_flush_o && !rx_on |=> !rx_en_o);
endmodule

// File: tb/test_uart_regs.sv
`timescale 1ns/1ps
module test_uart_regs;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic [5:0] addr_i = '0;
  logic wr_i = 1'b0, rd_i = 1'b0, brk_evt_i = 1'b0;
  logic [7:0] wdata_i = '0, rx_data_i = '0;
  logic rx_ready_i = 1'b0, rx_full_i = 1'b0;
  logic [3:0] rx_err_i = '0;
  logic [15:0] baud_div_i = 16'h1234;
  logic [7:0] rdata_o, tx_data_o;
  logic irq_o, tx_valid_o, rx_pop_o, rx_flush_o, rx_en_o;

  always #5 clk = ~clk;

  uart_regs i_uart_regs (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o),
    .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .rx_data_i(rx_data_i),
    .rx_ready_i(rx_ready_i), .rx_full_i(rx_full_i), .rx_err_i(rx_err_i),
    .rx_pop_o(rx_pop_o), .rx_flush_o(rx_flush_o), .rx_en_o(rx_en_o),
    .brk_evt_i(brk_evt_i), .baud_div_i(baud_div_i)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_mr [2];
  logic m_ptr, m_txen, m_rxen, m_empty, m_brk;
  logic [7:0] m_tb, m_imr;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_sr();
    return {rx_err_i, m_empty, m_txen, rx_full_i, rx_ready_i};
  endfunction

  function automatic logic [7:0] exp_isr();
    return {5'b0, m_brk, (m_mr[0][6] ? rx_full_i : rx_ready_i), m_txen};
  endfunction

  function automatic logic [7:0] exp_rd(input logic [5:0] a);
    case (a)
      6'h00: return m_mr[m_ptr];
      6'h04: return exp_sr();
      6'h0C: return rx_data_i;
      6'h14: return exp_isr();
      6'h18: return baud_div_i[15:8];
      6'h1C: return baud_div_i[7:0];
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_reset();
    m_mr[0] = 0; m_mr[1] = 0; m_ptr = 0; m_txen = 0; m_rxen = 0;
    m_empty = 1; m_brk = 0; m_tb = 0; m_imr = 0;
  endtask

  // one bus cycle: drive at negedge, check combinational outputs, update model at posedge
  task automatic step(input string tag, input logic w, input logic r,
                      input logic [5:0] a, input logic [7:0] d, input logic b);
    @(negedge clk);
    wr_i = w; rd_i = r; addr_i = a; wdata_i = d; brk_evt_i = b;
    #1;
    check(tag, rdata_o, r ? exp_rd(a) : 8'h00);
    check("R11 irq", {7'b0, irq_o}, {7'b0, |(exp_isr() & m_imr)});
    check("R8 valid", {7'b0, tx_valid_o}, {7'b0, m_txen & ~m_empty});
    if (m_txen && !m_empty) check("R8 data", tx_data_o, m_tb);
    check("R12 pop", {7'b0, rx_pop_o}, {7'b0, r && a == 6'h0C});
    check("R6 flush", {7'b0, rx_flush_o}, {7'b0, w && a == 6'h08 && d[6:4] == 3'd2});
    check("R4 rx_en", {7'b0, rx_en_o}, {7'b0, m_rxen});
    @(posedge clk);
    if (m_txen && !m_empty) m_empty = 1;
    if (w) begin
      case (a)
        6'h00: begin m_mr[m_ptr] = d; m_ptr = 1; end
        6'h08: begin
          case (d[6:4])
            3'd1: m_ptr = 0;
            3'd2: m_rxen = 0;
            3'd3: begin m_txen = 0; m_empty = 1; end
            3'd5: m_brk = 0;
            default: ;
          endcase
          if (d[3:2] == 2'd1) m_txen = 1; else if (d[3:2] == 2'd2) m_txen = 0;
          if (d[1:0] == 2'd1) m_rxen = 1; else if (d[1:0] == 2'd2) m_rxen = 0;
        end
        6'h0C: begin m_tb = d; m_empty = 0; end
        6'h14: m_imr = d;
        default: ;
      endcase
    end
    if (b) m_brk = 1;
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    step("R12 idle", 1'b1, 1'b0, a, d, 1'b0);
  endtask

  task automatic rd(input string tag, input logic [5:0] a);
    step(tag, 1'b0, 1'b1, a, 8'h00, 1'b0);
  endtask

  initial begin
    #2000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    rd("R1 mode", 6'h00);
    rd("R1 status", 6'h04);
    rd("R1 isr", 6'h14);
    // R2 pointer
    wr(6'h00, 8'h11);
    wr(6'h00, 8'h22);
    rd("R2 mode1", 6'h00);
    wr(6'h08, 8'h10);
    rd("R2 mode0", 6'h00);
    // R8 pending while disabled, R5 enable
    wr(6'h0C, 8'hA5);
    rd("R8 empty clr", 6'h04);
    wr(6'h08, 8'h04);
    rd("R5 tx ready", 6'h04);
    // R8 back-to-back writes during hand-off
    wr(6'h0C, 8'h5A);
    wr(6'h0C, 8'hC3);
    rd("R8 after", 6'h04);
    // R7 transmitter reset drops pending byte
    wr(6'h08, 8'h08);
    wr(6'h0C, 8'h3C);
    wr(6'h08, 8'h30);
    rd("R7 status", 6'h04);
    wr(6'h08, 8'h04);
    wr(6'h08, 8'h34);
    rd("R7 reset+enable", 6'h04);
    // R6 / R4
    wr(6'h08, 8'h01);
    wr(6'h08, 8'h21);
    wr(6'h08, 8'h03);
    wr(6'h08, 8'h20);
    wr(6'h08, 8'h00);
    // R9 selectable receive source
    rx_full_i = 1'b1; rx_ready_i = 1'b0;
    rd("R9 src ready", 6'h14);
    wr(6'h08, 8'h10);
    wr(6'h00, 8'h40);
    rd("R9 src full", 6'h14);
    rx_err_i = 4'hA;
    rd("R3 status", 6'h04);
    // R10 break flag
    step("R10 evt", 1'b0, 1'b0, 6'h00, 8'h00, 1'b1);
    rd("R10 set", 6'h14);
    wr(6'h14, 8'h04);
    wr(6'h08, 8'h50);
    rd("R10 clr", 6'h14);
    step("R10 both", 1'b1, 1'b0, 6'h08, 8'h50, 1'b1);
    rd("R10 set wins", 6'h14);
    // R13 stray writes
    wr(6'h04, 8'hFF);
    wr(6'h10, 8'hFF);
    wr(6'h3D, 8'hFF);
    rd("R13 mode", 6'h00);
    rd("R13 isr", 6'h14);
    rd("R13 status", 6'h04);
    // R12 data and divisor
    rx_data_i = 8'h9E;
    rd("R12 data", 6'h0C);
    rd("R12 div hi", 6'h18);
    rd("R12 div lo", 6'h1C);
    rd("R12 other", 6'h10);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [5:0] a;
      logic [2:0] sel;
      int op;
      sel = 3'($urandom_range(0, 7));
      case (sel)
        3'd0: a = 6'h00; 3'd1: a = 6'h04; 3'd2: a = 6'h08; 3'd3: a = 6'h0C;
        3'd4: a = 6'h14; 3'd5: a = 6'h18; 3'd6: a = 6'h1C;
        default: a = 6'($urandom);
      endcase
      rx_data_i  = 8'($urandom);
      rx_ready_i = 1'($urandom);
      rx_full_i  = 1'($urandom);
      rx_err_i   = 4'($urandom);
      baud_div_i = 16'($urandom);
      op = $urandom_range(0, 9);
      step("R12 rand", op < 5, op >= 5, a, 8'($urandom), $urandom_range(0, 19) == 0);
    end
    step("R12 end", 1'b0, 1'b0, 6'h00, 8'h00, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule